// File: doc/BRIEF.md
# Calendar Time Counter with Maskable Alarm

This block keeps wall-clock time as seven binary fields: seconds, minutes, hours, day of month, day of week, month and year. A one-cycle pulse on the tick input advances it by one second. Carries pass from seconds up through the year. The day-of-month limit depends on the month, and February has 29 days when the year is divisible by four. The year is held as an offset from 2000 in seven bits, so it covers 2000 to 2127.

Writes from the surrounding register logic arrive as committed load strobes, each with a full value. One strobe loads the time, one the alarm, one the alarm mask and one the interrupt enables. One cycle after each tick, the updated time is compared with the alarm field by field, and fields whose mask bit is set are skipped. Two status bits latch the alarm and tick events, and a read strobe clears them. An active-low level interrupt is held low while any status bit is set. In one-shot mode the alarm disarms itself when it fires.

Top module: `cal_alarm_timer`

## Requirements
- R1: After reset the time reads second 0, minute 0, hour 0, day-of-month 1, day-of-week 1, month 1, year offset 0. Status, enables and mask are all zero, and `irq_n_o` is high.
- R2: A load strobe on the time, alarm, mask or enable input makes the value visible from the next clock edge. A time load in the same cycle as a tick takes priority, and the loaded value is not advanced.
- R3: On a tick, seconds go from 59 to 0 and carry into minutes. Minutes go from 59 to 0 and carry into hours. Hours go from 23 to 0 and carry into the day. On a day carry, the day of month returns to 1 after the last day of the month and the day of week goes from 7 to 1. The last day is 30 for months 4, 6, 9 and 11, 31 for other months, and for February 29 when the year offset modulo 4 is 0 and 28 otherwise. After month 12 a month carry gives month 1 and increments the year, which wraps from 127 to 0.
- R4: The time and alarm buses pack the fields from the LSB in this order: seconds [5:0], minutes [11:6], hours [16:12], day of month [21:17], day of week [24:22], month [28:25], year offset [35:29].
- R5: At the clock edge after a tick, status bit 0 sets if enable bit 0 is set and every unmasked field of the updated time equals the alarm. The comparison runs once per tick and not at any other time. With enable bit 0 clear the bit does not set.
- R6: Mask bit i excludes field i from the comparison. The bits map 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 day of week, 5 month, 6 year. With all seven bits set, the alarm matches on every tick.
- R7: A tick while enable bit 1 is set sets status bit 1 at the same clock edge that advances the time.
- R8: A read strobe clears both status bits at the next edge. An event that sets a bit at that same edge still leaves the bit set.
- R9: When enable bit 2 (one-shot) is set and the alarm fires, enable bit 0 clears at the same edge. Later matches then do not set status bit 0.
- R10: `irq_n_o` is low exactly while the status is nonzero and changes at the same edge as the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second advance pulse, one cycle wide |
| time_ld_i | input | 1 | Load strobe for the time |
| time_val_i | input | 36 | Time value to load, packed as in R4 |
| alm_ld_i | input | 1 | Load strobe for the alarm |
| alm_val_i | input | 36 | Alarm value to load, packed as in R4 |
| mask_ld_i | input | 1 | Load strobe for the alarm mask |
| mask_val_i | input | 7 | Mask value, one bit per field |
| ien_ld_i | input | 1 | Load strobe for the interrupt enables |
| ien_val_i | input | 3 | Enables: bit 0 alarm, bit 1 tick, bit 2 one-shot |
| sts_rd_i | input | 1 | Status read strobe; clears the status |
| time_o | output | 36 | Current time |
| sts_o | output | 2 | Status: bit 0 alarm, bit 1 tick |
| ien_o | output | 3 | Current interrupt enables |
| irq_n_o | output | 1 | Level interrupt, active low |

## Verification
The time and the tick status bit change at the edge that samples the tick. The alarm status bit changes one edge later, because the comparison uses the registered time. The bench therefore pulses the tick between two falling edges and reads all results at the falling edge after the following rising edge, by which point both latencies have passed. Loads and read strobes also last one falling-edge-to-falling-edge window, and their effects are sampled at the next falling edge.

// File: rtl/cal_pkg.sv
package cal_pkg;
   localparam int NFLD  = 7;
   localparam int F_SEC = 0;
   localparam int F_MIN = 1;
   localparam int F_HR  = 2;
   localparam int F_DOM = 3;
   localparam int F_DOW = 4;
   localparam int F_MON = 5;
   localparam int F_YR  = 6;

   localparam int W_SEC = 6;
   localparam int W_MIN = 6;
   localparam int W_HR  = 5;
   localparam int W_DOM = 5;
   localparam int W_DOW = 3;
   localparam int W_MON = 4;
   localparam int W_YR  = 7;

   function automatic int fld_w(input int idx);
      case (idx)
         F_SEC:   return W_SEC;
         F_MIN:   return W_MIN;
         F_HR:    return W_HR;
         F_DOM:   return W_DOM;
         F_DOW:   return W_DOW;
         F_MON:   return W_MON;
         default: return W_YR;
      endcase
   endfunction

   function automatic int fld_off(input int idx);
      int acc;
      acc = 0;
      for (int k = 0; k < idx; k++) acc += fld_w(k);
      return acc;
   endfunction

   localparam int TW = fld_off(NFLD);

   // last calendar day of a month; leap when the year offset is a multiple of 4
   function automatic logic [W_DOM-1:0] month_last_day(input logic [W_MON-1:0] mon,
                                                       input logic leap);
      case (mon)
         4'd2:                    return leap ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
         default:                 return 5'd31;
      endcase
   endfunction
endpackage

// File: rtl/cal_time_counter.sv
module cal_time_counter
   import cal_pkg::*;
#(
   parameter int SEC_LAST = 59,
   parameter int MIN_LAST = 59,
   parameter int HR_LAST  = 23,
   parameter int MON_LAST = 12,
   parameter int DOW_LAST = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          ld_i,
   input  logic [TW-1:0] ld_val_i,
   output logic [TW-1:0] time_o
);
   localparam logic [W_SEC-1:0] SEC_TOP = SEC_LAST[W_SEC-1:0];
   localparam logic [W_MIN-1:0] MIN_TOP = MIN_LAST[W_MIN-1:0];
   localparam logic [W_HR-1:0]  HR_TOP  = HR_LAST[W_HR-1:0];
   localparam logic [W_MON-1:0] MON_TOP = MON_LAST[W_MON-1:0];
   localparam logic [W_DOW-1:0] DOW_TOP = DOW_LAST[W_DOW-1:0];

   generate
      if (SEC_LAST >= (1 << W_SEC) || MIN_LAST >= (1 << W_MIN) ||
          HR_LAST >= (1 << W_HR) || MON_LAST >= (1 << W_MON) ||
          DOW_LAST >= (1 << W_DOW)) begin : g_bad_limit
         $error("cal_time_counter: a field limit does not fit its width");
      end
   endgenerate

   logic [W_SEC-1:0] sec_q, sec_n;
   logic [W_MIN-1:0] min_q, min_n;
   logic [W_HR-1:0]  hr_q,  hr_n;
   logic [W_DOM-1:0] dom_q, dom_n;
   logic [W_DOW-1:0] dow_q, dow_n;
   logic [W_MON-1:0] mon_q, mon_n;
   logic [W_YR-1:0]  yr_q,  yr_n;

   logic             c_min, c_hr, c_day, c_mon, c_yr;
   logic [W_DOM-1:0] last_dom;

   assign last_dom = month_last_day(mon_q, (yr_q[1:0] == 2'b00));

   // carry chain; a value at or past its limit wraps, so bad loads recover
   assign c_min = (sec_q >= SEC_TOP);
   assign c_hr  = c_min & (min_q >= MIN_TOP);
   assign c_day = c_hr  & (hr_q  >= HR_TOP);
   assign c_mon = c_day & (dom_q >= last_dom);
   assign c_yr  = c_mon & (mon_q >= MON_TOP);

   always_comb begin
      sec_n = sec_q;
      min_n = min_q;
      hr_n  = hr_q;
      dom_n = dom_q;
      dow_n = dow_q;
      mon_n = mon_q;
      yr_n  = yr_q;
      if (ld_i) begin
         sec_n = ld_val_i[fld_off(F_SEC) +: W_SEC];
         min_n = ld_val_i[fld_off(F_MIN) +: W_MIN];
         hr_n  = ld_val_i[fld_off(F_HR)  +: W_HR];
         dom_n = ld_val_i[fld_off(F_DOM) +: W_DOM];
         dow_n = ld_val_i[fld_off(F_DOW) +: W_DOW];
         mon_n = ld_val_i[fld_off(F_MON) +: W_MON];
         yr_n  = ld_val_i[fld_off(F_YR)  +: W_YR];
      end else if (tick_i) begin
         sec_n = c_min ? '0 : sec_q + 1'b1;
         if (c_min) min_n = c_hr  ? '0 : min_q + 1'b1;
         if (c_hr)  hr_n  = c_day ? '0 : hr_q + 1'b1;
         if (c_day) begin
            dom_n = c_mon ? W_DOM'(1) : dom_q + 1'b1;
            dow_n = (dow_q >= DOW_TOP) ? W_DOW'(1) : dow_q + 1'b1;
         end
         if (c_mon) mon_n = c_yr ? W_MON'(1) : mon_q + 1'b1;
         if (c_yr)  yr_n  = yr_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q <= '0;
         min_q <= '0;
         hr_q  <= '0;
         dom_q <= W_DOM'(1);
         dow_q <= W_DOW'(1);
         mon_q <= W_MON'(1);
         yr_q  <= '0;
      end else begin
         sec_q <= sec_n;
         min_q <= min_n;
         hr_q  <= hr_n;
         dom_q <= dom_n;
         dow_q <= dow_n;
         mon_q <= mon_n;
         yr_q  <= yr_n;
      end
   end

   assign time_o = {yr_q, mon_q, dow_q, dom_q, hr_q, min_q, sec_q};
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
   import cal_pkg::*;
(
   input  logic [TW-1:0]   now_i,
   input  logic [TW-1:0]   alm_i,
   input  logic [NFLD-1:0] mask_i,
   output logic            hit_o
);
   logic [NFLD-1:0] fld_ok;

   generate
      for (genvar g = 0; g < NFLD; g++) begin : g_fld
         localparam int OFF = fld_off(g);
         localparam int WID = fld_w(g);
         assign fld_ok[g] = mask_i[g] | (now_i[OFF +: WID] == alm_i[OFF +: WID]);
      end
   endgenerate

   assign hit_o = &fld_ok;
endmodule

// File: rtl/cal_irq_ctrl.sv
module cal_irq_ctrl #(
   parameter int EN_W  = 3,
   parameter int STS_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ien_ld_i,
   input  logic [EN_W-1:0]  ien_val_i,
   input  logic             tick_i,
   input  logic             chk_i,
   input  logic             hit_i,
   input  logic             sts_rd_i,
   output logic [STS_W-1:0] sts_o,
   output logic [EN_W-1:0]  ien_o,
   output logic             irq_n_o
);
   localparam int B_ALM  = 0;
   localparam int B_TICK = 1;
   localparam int B_ONE  = 2;

   generate
      if (EN_W < 3 || STS_W < 2) begin : g_bad_w
         $error("cal_irq_ctrl: enable or status field too narrow");
      end
   endgenerate

   logic [EN_W-1:0]  en_q;
   logic [STS_W-1:0] sts_q, sts_n, set_v;
   logic             irq_n_q, fire;

   assign fire = chk_i & hit_i & en_q[B_ALM];

   always_comb begin
      set_v         = '0;
      set_v[B_ALM]  = fire;
      set_v[B_TICK] = tick_i & en_q[B_TICK];
      sts_n         = (sts_rd_i ? '0 : sts_q) | set_v;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         sts_q   <= '0;
         irq_n_q <= 1'b1;
      end else begin
         if (ien_ld_i)                  en_q        <= ien_val_i;
         else if (fire && en_q[B_ONE])  en_q[B_ALM] <= 1'b0;
         sts_q   <= sts_n;
         irq_n_q <= ~|sts_n;
      end
   end

   assign sts_o   = sts_q;
   assign ien_o   = en_q;
   assign irq_n_o = irq_n_q;
endmodule

// File: rtl/cal_alarm_timer.sv
module cal_alarm_timer
   import cal_pkg::*;
#(
   parameter int SEC_LAST = 59,
   parameter int MIN_LAST = 59,
   parameter int HR_LAST  = 23,
   parameter int MON_LAST = 12,
   parameter int DOW_LAST = 7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick_i,
   input  logic        time_ld_i,
   input  logic [35:0] time_val_i,
   input  logic        alm_ld_i,
   input  logic [35:0] alm_val_i,
   input  logic        mask_ld_i,
   input  logic [6:0]  mask_val_i,
   input  logic        ien_ld_i,
   input  logic [2:0]  ien_val_i,
   input  logic        sts_rd_i,
   output logic [35:0] time_o,
   output logic [1:0]  sts_o,
   output logic [2:0]  ien_o,
   output logic        irq_n_o
);
   generate
      if (TW != 36 || NFLD != 7) begin : g_bad_pack
         $error("cal_alarm_timer: field packing does not match the port widths");
      end
   endgenerate

   logic [TW-1:0]   alm_q;
   logic [NFLD-1:0] mask_q;
   logic            chk_q;
   logic            hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alm_q  <= '0;
         mask_q <= '0;
         chk_q  <= 1'b0;
      end else begin
         if (alm_ld_i)  alm_q  <= alm_val_i;
         if (mask_ld_i) mask_q <= mask_val_i;
         chk_q <= tick_i;
      end
   end

   cal_time_counter #(
      .SEC_LAST (SEC_LAST),
      .MIN_LAST (MIN_LAST),
      .HR_LAST  (HR_LAST),
      .MON_LAST (MON_LAST),
      .DOW_LAST (DOW_LAST)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .ld_i     (time_ld_i),
      .ld_val_i (time_val_i),
      .time_o   (time_o)
   );

   cal_alarm_match u_cmp (
      .now_i  (time_o),
      .alm_i  (alm_q),
      .mask_i (mask_q),
      .hit_o  (hit)
   );

   cal_irq_ctrl #(
      .EN_W  (3),
      .STS_W (2)
   ) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ien_ld_i  (ien_ld_i),
      .ien_val_i (ien_val_i),
      .tick_i    (tick_i),
      .chk_i     (chk_q),
      .hit_i     (hit),
      .sts_rd_i  (sts_rd_i),
      .sts_o     (sts_o),
      .ien_o     (ien_o),
      .irq_n_o   (irq_n_o)
   );
endmodule

// File: rtl/cal_alarm_timer_chk.sv
module cal_alarm_timer_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        tick_i,
   input logic        time_ld_i,
   input logic [35:0] time_val_i,
   input logic        ien_ld_i,
   input logic        sts_rd_i,
   input logic [35:0] time_o,
   input logic [1:0]  sts_o,
   input logic [2:0]  ien_o,
   input logic        irq_n_o
);
   a_r2_time_load: assert property (@(posedge clk) disable iff (!rst_n)
      time_ld_i |=> (time_o == $past(time_val_i)));

   a_r3_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !time_ld_i) |=> (time_o[5:0] <= 6'd59));

   a_r5_alarm_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_o[0]) |-> $past(tick_i, 2));

   a_r7_tick_sts: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && ien_o[1]) |=> sts_o[1]);

   a_r8_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_rd_i && !tick_i && !$past(tick_i)) |=> (sts_o == 2'b00));

   a_r9_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sts_o[0]) && $past(ien_o[2]) && !$past(ien_ld_i)) |-> !ien_o[0]);

   a_r10_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_o != 2'b00) |-> !irq_n_o);
endmodule

bind cal_alarm_timer cal_alarm_timer_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_i     (tick_i),
   .time_ld_i  (time_ld_i),
   .time_val_i (time_val_i),
   .ien_ld_i   (ien_ld_i),
   .sts_rd_i   (sts_rd_i),
   .time_o     (time_o),
   .sts_o      (sts_o),
   .ien_o      (ien_o),
   .irq_n_o    (irq_n_o)
);

// File: tb/cal_alarm_timer_test.sv
module cal_alarm_timer_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        time_ld_i = 1'b0;
   logic [35:0] time_val_i = '0;
   logic        alm_ld_i = 1'b0;
   logic [35:0] alm_val_i = '0;
   logic        mask_ld_i = 1'b0;
   logic [6:0]  mask_val_i = '0;
   logic        ien_ld_i = 1'b0;
   logic [2:0]  ien_val_i = '0;
   logic        sts_rd_i = 1'b0;
   logic [35:0] time_o;
   logic [1:0]  sts_o;
   logic [2:0]  ien_o;
   logic        irq_n_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   cal_alarm_timer uut (.*);

   // field order per R4: sec, min, hr, dom, dow, mon, yr from the LSB
   function automatic logic [35:0] tp(input int s, input int mn, input int h,
                                      input int d, input int w, input int mo,
                                      input int y);
      logic [6:0] yv; logic [3:0] mov; logic [2:0] wv; logic [4:0] dv;
      logic [4:0] hv; logic [5:0] mv; logic [5:0] sv;
      yv = y[6:0]; mov = mo[3:0]; wv = w[2:0]; dv = d[4:0];
      hv = h[4:0]; mv = mn[5:0]; sv = s[5:0];
      return {yv, mov, wv, dv, hv, mv, sv};
   endfunction

   typedef struct packed {
      logic [35:0] st;
      logic [35:0] al;
      logic [6:0]  mk;
      logic [35:0] ex;
      logic        fire;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t TBL [NV] = '{
      '{tp(10,5,3,15,3,6,24),   tp(11,5,3,15,3,6,24), 7'h00, tp(11,5,3,15,3,6,24), 1'b1},
      '{tp(59,5,3,15,3,6,24),   tp(1,6,3,15,3,6,24),  7'h00, tp(0,6,3,15,3,6,24),  1'b0},
      '{tp(59,59,23,15,3,6,24), tp(0,0,0,16,1,6,24),  7'h10, tp(0,0,0,16,4,6,24),  1'b1},
      '{tp(59,59,23,30,7,4,24), tp(0,0,0,1,3,5,24),   7'h00, tp(0,0,0,1,1,5,24),   1'b0},
      '{tp(59,59,23,28,5,2,24), tp(0,0,0,29,6,2,24),  7'h00, tp(0,0,0,29,6,2,24),  1'b1},
      '{tp(59,59,23,28,5,2,23), tp(0,0,0,0,0,0,0),    7'h00, tp(0,0,0,1,6,3,23),   1'b0},
      '{tp(59,59,23,29,2,2,24), tp(0,0,0,1,3,3,25),   7'h40, tp(0,0,0,1,3,3,24),   1'b1},
      '{tp(59,59,23,31,4,12,24),tp(30,0,0,1,5,1,25),  7'h00, tp(0,0,0,1,5,1,25),   1'b0},
      '{tp(59,59,23,31,6,12,127),tp(0,0,0,1,7,1,0),   7'h00, tp(0,0,0,1,7,1,0),    1'b1},
      '{tp(20,1,1,1,1,1,1),     tp(0,0,0,0,0,0,0),    7'h7f, tp(21,1,1,1,1,1,1),   1'b1},
      '{tp(10,5,3,15,3,6,24),   tp(11,6,3,15,3,6,24), 7'h00, tp(11,5,3,15,3,6,24), 1'b0}
   };

   task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic load_all(input logic [35:0] t, input logic [35:0] a,
                           input logic [6:0] m, input logic [2:0] e);
      @(negedge clk);
      time_ld_i = 1'b1; time_val_i = t;
      alm_ld_i = 1'b1;  alm_val_i = a;
      mask_ld_i = 1'b1; mask_val_i = m;
      ien_ld_i = 1'b1;  ien_val_i = e;
      @(negedge clk);
      time_ld_i = 1'b0; alm_ld_i = 1'b0; mask_ld_i = 1'b0; ien_ld_i = 1'b0;
   endtask

   task automatic rd_sts();
      @(negedge clk); sts_rd_i = 1'b1;
      @(negedge clk); sts_rd_i = 1'b0;
   endtask

   // time and tick status at the first rising edge, alarm status at the second
   task automatic do_tick();
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 time", time_o, tp(0,0,0,1,1,1,0));
      check("R1 sts", {34'b0, sts_o}, 36'h0);
      check("R1 ien", {33'b0, ien_o}, 36'h0);
      check("R1 irq_n", {35'b0, irq_n_o}, 36'h1);

      // table walk: R3 R4 calendar advance, R5 R6 alarm compare
      for (int i = 0; i < NV; i++) begin
         load_all(TBL[i].st, TBL[i].al, TBL[i].mk, 3'b001);
         rd_sts();
         do_tick();
         check($sformatf("R3 R4 vec%0d time", i), time_o, TBL[i].ex);
         check($sformatf("R5 R6 vec%0d alarm", i), {35'b0, sts_o[0]}, {35'b0, TBL[i].fire});
      end

      // R7 tick status and R10 interrupt level
      load_all(tp(0,0,0,1,1,1,0), '0, 7'h00, 3'b010);
      rd_sts();
      do_tick();
      check("R7 tick sts", {34'b0, sts_o}, 36'h2);
      check("R10 irq low", {35'b0, irq_n_o}, 36'h0);
      // R8 read clears, R10 released
      rd_sts();
      check("R8 cleared", {34'b0, sts_o}, 36'h0);
      check("R10 irq high", {35'b0, irq_n_o}, 36'h1);
      // R8 set wins over clear in the same cycle
      @(negedge clk); sts_rd_i = 1'b1; tick_i = 1'b1;
      @(negedge clk); sts_rd_i = 1'b0; tick_i = 1'b0;
      @(negedge clk);
      check("R8 set beats clear", {35'b0, sts_o[1]}, 36'h1);

      // R5 alarm disabled: no status even with every field masked
      load_all(tp(0,0,0,1,1,1,0), '0, 7'h7f, 3'b000);
      rd_sts();
      do_tick();
      check("R5 disabled", {34'b0, sts_o}, 36'h0);

      // R9 one-shot disarms on fire
      load_all(tp(0,0,0,1,1,1,0), '0, 7'h7f, 3'b101);
      rd_sts();
      do_tick();
      check("R9 fired", {35'b0, sts_o[0]}, 36'h1);
      check("R9 enable cleared", {33'b0, ien_o}, 36'h4);
      rd_sts();
      do_tick();
      check("R9 no refire", {35'b0, sts_o[0]}, 36'h0);

      // R5 repeating mode fires on each matching tick
      load_all(tp(0,0,0,1,1,1,0), '0, 7'h7f, 3'b001);
      rd_sts();
      do_tick();
      check("R5 repeat first", {35'b0, sts_o[0]}, 36'h1);
      rd_sts();
      do_tick();
      check("R5 repeat second", {35'b0, sts_o[0]}, 36'h1);
      check("R5 enable kept", {33'b0, ien_o}, 36'h1);

      // R2 load beats tick in the same cycle
      @(negedge clk); tick_i = 1'b1; time_ld_i = 1'b1; time_val_i = tp(30,30,12,10,2,8,50);
      @(negedge clk); tick_i = 1'b0; time_ld_i = 1'b0;
      check("R2 load priority", time_o, tp(30,30,12,10,2,8,50));

      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule